// File: doc/BRIEF.md
# Pattern and Edge Qualified Capture Trigger

This block decides when a capture system should start recording. On every clock where the sample enable is high, it checks a word of input channels against a condition set separately for each channel. Each channel can require a low level, a high level, a rising edge or a falling edge, or it can be ignored. The combined match must hold over a programmed number of consecutive enabled samples before it counts as one event. Once a programmed number of events has been seen, the block raises a one-cycle trigger pulse.

Instead of the channel pattern, software can select an external trigger line as the source of events. That line passes through a synchroniser, and each rising edge counts as one event. The block is started by an arm pulse. After it fires, it stays quiet until it is armed again. Configuration is expected to stay constant while the block is armed.

Top module: `pat_trig`

## Requirements
- R1: After reset the block is idle: `trig_out` is 0, and matching samples produce no trigger until `arm` is pulsed.
- R2: Per-channel code field `cond_cfg[3*i+2:3*i]` selects the channel's condition: 3'd0 = ignored, 3'd1 = sample bit low, 3'd2 = sample bit high. A sample matches only when every channel's condition holds at once.
- R3: Code 3'd3 requires the bit to be 0 in the previous enabled sample and 1 in the current one. Code 3'd4 requires 1 then 0. Codes 3'd5 to 3'd7 behave as ignored.
- R4: The first enabled sample after `arm` never satisfies an edge code, whatever was sampled before arming. A sample presented in the same cycle as `arm` is discarded.
- R5: An event occurs on the enabled sample at which the run of consecutive matching samples reaches `width_m1`+1. This covers the full range of 1 to 16. Cycles with `smp_en` low neither extend nor break the run, whatever data they carry.
- R6: An enabled sample that does not match resets the run length to zero.
- R7: A single unbroken run produces only one event. The trigger fires on event number `count_m1`+1, in the range 1 to 16.
- R8: `trig_out` goes high for exactly one cycle, in the cycle that follows the clock edge that accepted the firing sample.
- R9: After firing, the block ignores all matches until `arm` is pulsed again. Pulsing `arm` while armed restarts the run and event counts from zero.
- R10: With `src_ext` = 1, `ext_trig` passes through two synchronising flops. Each rising edge then counts as one event, and channel matches are ignored. A rising edge presented before clock edge a is counted at edge a+2.
- R11: With `src_ext` = 0, `ext_trig` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle start pulse; clears counts and enables firing |
| src_ext | input | 1 | 1 selects the external line as event source |
| cond_cfg | input | 3*N_CH | Per-channel condition codes |
| width_m1 | input | CNT_W | Minimum run length minus one |
| count_m1 | input | CNT_W | Required event count minus one |
| smp_en | input | 1 | Sample-enable strobe |
| smp_data | input | N_CH | Channel sample word |
| ext_trig | input | 1 | Asynchronous external trigger line |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The pattern stimulus covers several cases. Multi-channel level words differ from the target in a single bit, which separates a true all-channel match from a partial one. Edge sequences include a stale sample taken before arming, which shows whether the previous-sample register is cleared. Runs are broken either by mismatches or by gaps in the sample enable, which tells a run reset apart from a pause. Both ends of the width and count ranges (1 and 16) are used, which exposes off-by-one errors in the encoding as value minus one. Finally, the external line is held high, toggled and mixed with matching patterns, which shows that only synchronised rising edges in the selected mode produce events.

// File: rtl/pat_trig_pkg.sv
package pat_trig_pkg;

   localparam int unsigned COND_W = 3;

   typedef enum logic [COND_W-1:0] {
      COND_ANY  = 3'd0,
      COND_LOW  = 3'd1,
      COND_HIGH = 3'd2,
      COND_RISE = 3'd3,
      COND_FALL = 3'd4
   } cond_e;

   // Evaluate one channel condition; unused codes act as "ignored".
   function automatic logic cond_ok(input logic [COND_W-1:0] code,
                                    input logic cur,
                                    input logic prv,
                                    input logic prv_ok);
      logic r;
      case (code)
         COND_LOW:  r = ~cur;
         COND_HIGH: r = cur;
         COND_RISE: r = prv_ok & ~prv & cur;
         COND_FALL: r = prv_ok & prv & ~cur;
         default:   r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pat_trig_match.sv
module pat_trig_match
   import pat_trig_pkg::*;
#(
   parameter int unsigned N_CH = 16
) (
   input  logic [COND_W*N_CH-1:0] cond_cfg,
   input  logic [N_CH-1:0]        cur,
   input  logic [N_CH-1:0]        prv,
   input  logic                   prv_ok,
   output logic                   hit
);

   logic [N_CH-1:0] bit_ok;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      always_comb begin
         bit_ok[i] = cond_ok(cond_cfg[COND_W*i +: COND_W], cur[i], prv[i], prv_ok);
      end
   end

   assign hit = &bit_ok;

endmodule

// File: rtl/pat_trig_width.sv
module pat_trig_width #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             hit,
   input  logic [CNT_W-1:0] width_m1,
   output logic             event_o,
   output logic [CNT_W:0]   run_cnt
);

   localparam int unsigned RUN_W = CNT_W + 1;

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] lim;

   assign lim     = {1'b0, width_m1};
   assign event_o = step & hit & (run_q == lim);
   assign run_cnt = run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         run_q <= '0;
      end else if (step) begin
         if (!hit) begin
            run_q <= '0;
         end else if (run_q <= lim) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pat_trig_count.sv
module pat_trig_count #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ev,
   input  logic [CNT_W-1:0] count_m1,
   output logic             fire,
   output logic [CNT_W-1:0] ev_cnt
);

   logic [CNT_W-1:0] cnt_q;

   assign fire   = ev & (cnt_q == count_m1);
   assign ev_cnt = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (ev && !fire) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pat_trig_sync.sv
module pat_trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pat_trig.sv
module pat_trig
   import pat_trig_pkg::*;
#(
   parameter int unsigned N_CH        = 16,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   arm,
   input  logic                   src_ext,
   input  logic [COND_W*N_CH-1:0] cond_cfg,
   input  logic [CNT_W-1:0]       width_m1,
   input  logic [CNT_W-1:0]       count_m1,
   input  logic                   smp_en,
   input  logic [N_CH-1:0]        smp_data,
   input  logic                   ext_trig,
   output logic                   trig_out
);

   if (N_CH < 1) begin : g_bad_nch
      $error("pat_trig: N_CH must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pat_trig: CNT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pat_trig: SYNC_STAGES must be at least 2");
   end

   logic            armed_q;
   logic            trig_q;
   logic [N_CH-1:0] prev_q;
   logic            prev_ok_q;

   logic            live;
   logic            step;
   logic            pat_hit;
   logic            pat_ev;
   logic            ext_rise;
   logic            ev_sel;
   logic            fire;
   logic [CNT_W:0]  run_cnt;
   logic [CNT_W-1:0] ev_cnt;

   // A cycle carrying arm restarts everything and discards its sample.
   assign live = armed_q & ~arm;
   assign step = live & smp_en & ~src_ext;

   pat_trig_match #(.N_CH(N_CH)) u_match (
      .cond_cfg (cond_cfg),
      .cur      (smp_data),
      .prv      (prev_q),
      .prv_ok   (prev_ok_q),
      .hit      (pat_hit)
   );

   pat_trig_width #(.CNT_W(CNT_W)) u_width (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (arm),
      .step     (step),
      .hit      (pat_hit),
      .width_m1 (width_m1),
      .event_o  (pat_ev),
      .run_cnt  (run_cnt)
   );

   pat_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_trig),
      .rise  (ext_rise)
   );

   assign ev_sel = src_ext ? (ext_rise & live) : pat_ev;

   pat_trig_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (arm),
      .ev       (ev_sel),
      .count_m1 (count_m1),
      .fire     (fire),
      .ev_cnt   (ev_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         trig_q    <= 1'b0;
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
      end else begin
         trig_q <= fire;
         if (arm) begin
            armed_q   <= 1'b1;
            prev_ok_q <= 1'b0;
         end else begin
            if (fire) armed_q <= 1'b0;
            if (step) begin
               prev_q    <= smp_data;
               prev_ok_q <= 1'b1;
            end
         end
      end
   end

   assign trig_out = trig_q;

endmodule

// File: rtl/pat_trig_chk.sv
module pat_trig_chk #(
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             smp_en,
   input logic             src_ext,
   input logic [CNT_W-1:0] count_m1,
   input logic             trig_out,
   input logic             armed_q,
   input logic             pat_hit,
   input logic [CNT_W:0]   run_cnt,
   input logic [CNT_W-1:0] ev_cnt,
   input logic             ext_rise
);

   // R8: the trigger is a single-cycle pulse
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   // R9: firing leaves the unit disarmed
   p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> !armed_q);

   // R9: only an armed unit can fire
   p_fire_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> $past(armed_q));

   // R4: an arm cycle never produces a trigger
   p_arm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm) |-> !trig_out);

   // R6: a non-matching enabled sample clears the run length
   p_run_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !arm && smp_en && !src_ext && !pat_hit) |=> (run_cnt == '0));

   // R7: the event count never passes its limit while armed
   p_evcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (ev_cnt <= count_m1));

   // R10: in external mode a trigger follows a synchronised rising edge
   p_ext_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_out && $past(src_ext)) |-> $past(ext_rise));

endmodule

bind pat_trig pat_trig_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm      (arm),
   .smp_en   (smp_en),
   .src_ext  (src_ext),
   .count_m1 (count_m1),
   .trig_out (trig_out),
   .armed_q  (armed_q),
   .pat_hit  (pat_hit),
   .run_cnt  (run_cnt),
   .ev_cnt   (ev_cnt),
   .ext_rise (ext_rise)
);

// File: tb/pat_trig_bench.sv
module pat_trig_bench;

   localparam int N_CH  = 16;
   localparam int CNT_W = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                arm = 1'b0;
   logic                src_ext = 1'b0;
   logic [3*N_CH-1:0]   cond_cfg = '0;
   logic [CNT_W-1:0]    width_m1 = '0;
   logic [CNT_W-1:0]    count_m1 = '0;
   logic                smp_en = 1'b0;
   logic [N_CH-1:0]     smp_data = '0;
   logic                ext_trig = 1'b0;
   logic                trig_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   pat_trig #(.N_CH(N_CH), .CNT_W(CNT_W)) u_pat_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .src_ext  (src_ext),
      .cond_cfg (cond_cfg),
      .width_m1 (width_m1),
      .count_m1 (count_m1),
      .smp_en   (smp_en),
      .smp_data (smp_data),
      .ext_trig (ext_trig),
      .trig_out (trig_out)
   );

   function automatic logic [3*N_CH-1:0] cset(input logic [3*N_CH-1:0] v,
                                              input int ch, input logic [2:0] code);
      logic [3*N_CH-1:0] r;
      r = v;
      r[3*ch +: 3] = code;
      return r;
   endfunction

   // Driver: one clock cycle of stimulus plus the trig_out expected after its edge
   task automatic cyc(input logic [N_CH-1:0] d, input bit en, input bit a,
                      input bit x, input bit e, input string tag);
      @(negedge clk);
      smp_data = d;
      smp_en   = en;
      arm      = a;
      ext_trig = x;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic cfg(input logic [3*N_CH-1:0] c, input logic [CNT_W-1:0] w,
                      input logic [CNT_W-1:0] n, input bit sx);
      @(negedge clk);
      cond_cfg = c;
      width_m1 = w;
      count_m1 = n;
      src_ext  = sx;
      arm      = 1'b0;
      smp_en   = 1'b0;
   endtask

   // Monitor: compares after each edge, away from the edge itself
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (trig_out !== e) begin
               n_bad++;
               $display("FAIL %s: trig_out=%0b expected %0b at %0t", t, trig_out, e, $time);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3*N_CH-1:0] c;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: never armed, matching samples give nothing
      cfg(cset('0, 0, 3'd2), 4'd0, 4'd0, 1'b0);
      cyc(16'h0001, 1, 0, 0, 0, "R1");
      cyc(16'h0001, 1, 0, 0, 0, "R1");
      cyc(16'h0001, 1, 0, 0, 0, "R1");

      // R2/R8/R9: single-bit high level
      cyc(16'h0001, 1, 1, 0, 0, "R4 arm cycle");
      cyc(16'h0001, 1, 0, 0, 1, "R2");
      cyc(16'h0001, 1, 0, 0, 0, "R8");
      cyc(16'h0001, 1, 0, 0, 0, "R9");

      // R2: multi-channel level pattern
      c = cset('0, 0, 3'd2);
      c = cset(c, 3, 3'd1);
      c = cset(c, 15, 3'd2);
      cfg(c, 4'd0, 4'd0, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R2");
      cyc(16'h8009, 1, 0, 0, 0, "R2");
      cyc(16'h0001, 1, 0, 0, 0, "R2");
      cyc(16'h80F1, 1, 0, 0, 1, "R2");

      // R3: falling edge
      cfg(cset('0, 5, 3'd4), 4'd0, 4'd0, 1'b0);
      cyc(16'h0020, 1, 1, 0, 0, "R4");
      cyc(16'h0020, 1, 0, 0, 0, "R4");
      cyc(16'h0000, 1, 0, 0, 1, "R3");

      // R4/R3: rising edge with stale pre-arm sample
      cfg(cset('0, 5, 3'd3), 4'd0, 4'd0, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R4");
      cyc(16'h0020, 1, 0, 0, 0, "R4");
      cyc(16'h0000, 1, 0, 0, 0, "R3");
      cyc(16'h0020, 1, 0, 0, 1, "R3");

      // R3: codes 5..7 ignored
      c = cset('0, 0, 3'd2);
      c = cset(c, 2, 3'd7);
      c = cset(c, 4, 3'd5);
      c = cset(c, 6, 3'd6);
      cfg(c, 4'd0, 4'd0, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R3");
      cyc(16'h0001, 1, 0, 0, 1, "R3");

      // R5/R6/R7: width 3, two events
      cfg(cset('0, 1, 3'd2), 4'd2, 4'd1, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R5");
      cyc(16'h0002, 1, 0, 0, 0, "R5");
      cyc(16'h0002, 1, 0, 0, 0, "R5");
      cyc(16'h0000, 0, 0, 0, 0, "R5 gap");
      cyc(16'h0002, 1, 0, 0, 0, "R5");
      cyc(16'h0002, 1, 0, 0, 0, "R7");
      cyc(16'h0000, 1, 0, 0, 0, "R6");
      cyc(16'h0002, 1, 0, 0, 0, "R6");
      cyc(16'h0002, 1, 0, 0, 0, "R6");
      cyc(16'h0000, 1, 0, 0, 0, "R6");
      cyc(16'h0002, 1, 0, 0, 0, "R6");
      cyc(16'h0002, 1, 0, 0, 0, "R6");
      cyc(16'h0002, 1, 0, 0, 1, "R7");

      // R5: width 16
      cfg(cset('0, 1, 3'd2), 4'd15, 4'd0, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R5");
      for (int i = 0; i < 16; i++) cyc(16'h0002, 1, 0, 0, (i == 15), "R5");

      // R7: count 16
      cfg(cset('0, 1, 3'd2), 4'd0, 4'd15, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R7");
      for (int i = 0; i < 16; i++) begin
         cyc(16'h0002, 1, 0, 0, (i == 15), "R7");
         cyc(16'h0000, 1, 0, 0, 0, "R7");
      end

      // R9: re-arm restarts counts
      cfg(cset('0, 0, 3'd2), 4'd0, 4'd1, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R9");
      cyc(16'h0001, 1, 0, 0, 0, "R9");
      cyc(16'h0001, 1, 1, 0, 0, "R9");
      cyc(16'h0001, 1, 0, 0, 0, "R9");
      cyc(16'h0000, 1, 0, 0, 0, "R9");
      cyc(16'h0001, 1, 0, 0, 1, "R9");

      // R10: external source, two rising edges, pattern ignored
      cfg(cset('0, 0, 3'd2), 4'd0, 4'd1, 1'b1);
      cyc(16'h0001, 1, 1, 0, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 0, "R10");
      for (int i = 0; i < 3; i++) cyc(16'h0001, 1, 0, 1, 0, "R10 held");
      for (int i = 0; i < 3; i++) cyc(16'h0001, 1, 0, 0, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 0, "R10");
      cyc(16'h0001, 1, 0, 1, 1, "R10");
      cyc(16'h0001, 1, 0, 0, 0, "R8");
      cyc(16'h0001, 1, 0, 0, 0, "R10");
      cyc(16'h0001, 1, 0, 0, 0, "R10");

      // R11: pattern mode ignores external line
      cfg(cset('0, 0, 3'd2), 4'd0, 4'd0, 1'b0);
      cyc(16'h0000, 1, 1, 0, 0, "R11");
      for (int i = 0; i < 8; i++) cyc(16'h0000, 1, 0, i[0], 0, "R11");
      cyc(16'h0001, 1, 0, 0, 1, "R11");
      cyc(16'h0000, 1, 0, 0, 0, "R8");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule